// File: doc/BRIEF.md
# Load fault supervisor for four low-side switches

This block supervises four low-side power switches. Each channel takes an active-low on command and drives one gate-enable output. Three digital comparator flags arrive per channel: drain above the overload level, drain below the open-load level, and drain below the lower short-to-ground level. Per-channel dwell counters filter these flags. Which fault a flag can produce depends on whether the switch is on or off. The block keeps one 2-bit fault code per channel, where a newer fault replaces an older one.

An overload that lasts long enough turns the switch off and keeps it off until its command is released and applied again. Open-load and short-to-ground faults are qualified only while the channel is commanded off, each with its own dwell. Short to ground has priority over open load. A one-cycle pulse per channel tells a serial reporting interface that a code was written. A clear input from that interface wipes all codes. An active-low reset, or an undervoltage flag, wipes all codes, releases all overload latches and holds every gate off.

Top module: `load_fault_supervisor`

## Requirements
- R1: gateEn[i] is high exactly when cmdN[i] is low, rstN is high, uvFlag is low and channel i holds no overload latch; bit i of every per-channel vector belongs to channel i.
- R2: While gateEn[i] is high, overFlag[i] sampled high on OVER_CYCLES consecutive clock edges writes code 2'b10 to channel i at the last of those edges and turns gateEn[i] off right after it.
- R3: After an overload shutdown, gateEn[i] stays off while cmdN[i] stays low; it turns on again only after cmdN[i] has been high for at least one edge and then goes low.
- R4: While cmdN[i] is high, openFlag[i] sampled high on OPEN_CYCLES consecutive edges writes code 2'b01.
- R5: While cmdN[i] is high, shortFlag[i] sampled high on SHORT_CYCLES consecutive edges writes code 2'b00; once the short dwell has completed (or completes on the same edge), an open-load dwell completion writes nothing.
- R6: A dwell count restarts from zero when its flag is sampled low for one edge, and when the channel's on/off state changes.
- R7: A newly qualified fault overwrites whatever code the channel already holds.
- R8: rstN low (asynchronous) or uvFlag high (at the next edge) sets every code to 2'b11 (no fault), clears all overload latches and dwell counts, and gateEn is all zero while either is active.
- R9: clearCodes high at an edge sets every code to 2'b11, except that a fault written to a channel at that same edge is kept.
- R10: errCode holds channel i's code in bits [2i+1:2i]; errPulse[i] is high for exactly the one cycle following each edge at which a code was written to channel i.
- R11: One continuous dwell episode writes its code once; holding the flag beyond the dwell produces no further pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, asynchronous |
| uvFlag | input | 1 | Supply undervoltage indication, active high |
| cmdN | input | NUM_CH | Per-channel on command, active low |
| overFlag | input | NUM_CH | Drain above overload level |
| openFlag | input | NUM_CH | Drain below open-load level |
| shortFlag | input | NUM_CH | Drain below short-to-ground level |
| clearCodes | input | 1 | Wipe all codes to no-fault |
| gateEn | output | NUM_CH | Per-channel switch enable |
| errCode | output | 2*NUM_CH | Two-bit fault code per channel |
| errPulse | output | NUM_CH | One-cycle pulse after a code write |

## Verification
The hardest situations to reach from the ports are a dwell that is one edge short of completion when a clear, a one-cycle flag gap or an on/off flip arrives, and the open-load dwell finishing after the short dwell already has. Directed sequences bring each channel to exactly one edge before its dwell limit and then apply the disturbing input. A random phase toggles commands and flags with low flip rates, so that flags often persist past the dwell limits, while rare clears, undervoltage pulses and resets land at arbitrary counter states. A bench model built from the requirements checks every cycle.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  typedef enum logic [1:0] {
    CODE_SHORT = 2'b00,
    CODE_OPEN  = 2'b01,
    CODE_OVER  = 2'b10,
    CODE_NONE  = 2'b11
  } faultCode_e;

  // per-channel write strobes from control to datapath
  typedef struct packed {
    logic recOver;
    logic recOpen;
    logic recShort;
  } chStrobe_t;

endpackage

// File: rtl/lfs_dwell_timer.sv
module lfs_dwell_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] FULL = CW'(LIMIT);

  logic [CW-1:0] count;

  // hit on the LIMIT-th consecutive edge with run high; saturate afterwards
  assign hit = run && (count == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '0;
    else if (!run)          count <= '0;
    else if (count != FULL) count <= count + 1'b1;
  end
endmodule

// File: rtl/lfs_datapath.sv
module lfs_datapath
  import lfs_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int OVER_CYCLES  = 8,
  parameter int OPEN_CYCLES  = 50,
  parameter int SHORT_CYCLES = 30
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH-1:0]       overFlag,
  input  logic [NUM_CH-1:0]       openFlag,
  input  logic [NUM_CH-1:0]       shortFlag,
  input  logic [NUM_CH-1:0]       onQual,
  input  logic [NUM_CH-1:0]       offQual,
  input  chStrobe_t [NUM_CH-1:0]  strobe,
  input  logic                    wipe,
  output logic [NUM_CH-1:0]       overHit,
  output logic [NUM_CH-1:0]       openHit,
  output logic [NUM_CH-1:0]       shortHit,
  output logic [NUM_CH-1:0]       shortDone,
  output logic [2*NUM_CH-1:0]     errCode,
  output logic [NUM_CH-1:0]       errPulse
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic       overRun, openRun, shortRun;
    logic       shortSeen;
    logic       anyRec;
    faultCode_e code;

    assign overRun  = overFlag[ch]  & onQual[ch];
    assign openRun  = openFlag[ch]  & offQual[ch];
    assign shortRun = shortFlag[ch] & offQual[ch];

    lfs_dwell_timer #(.LIMIT(OVER_CYCLES)) u_overTimer (
      .clk(clk), .rstN(rstN), .run(overRun), .hit(overHit[ch]));
    lfs_dwell_timer #(.LIMIT(OPEN_CYCLES)) u_openTimer (
      .clk(clk), .rstN(rstN), .run(openRun), .hit(openHit[ch]));
    lfs_dwell_timer #(.LIMIT(SHORT_CYCLES)) u_shortTimer (
      .clk(clk), .rstN(rstN), .run(shortRun), .hit(shortHit[ch]));

    // remembers that the current short episode has completed its dwell
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             shortSeen <= 1'b0;
      else if (!shortRun)    shortSeen <= 1'b0;
      else if (shortHit[ch]) shortSeen <= 1'b1;
    end
    assign shortDone[ch] = shortSeen;

    assign anyRec = strobe[ch].recOver | strobe[ch].recShort | strobe[ch].recOpen;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        code         <= CODE_NONE;
        errPulse[ch] <= 1'b0;
      end else begin
        errPulse[ch] <= anyRec;
        if (strobe[ch].recOver)       code <= CODE_OVER;
        else if (strobe[ch].recShort) code <= CODE_SHORT;
        else if (strobe[ch].recOpen)  code <= CODE_OPEN;
        else if (wipe)                code <= CODE_NONE;
      end
    end

    assign errCode[2*ch +: 2] = code;
  end

endmodule

// File: rtl/lfs_control.sv
module lfs_control
  import lfs_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    uvFlag,
  input  logic [NUM_CH-1:0]       cmdN,
  input  logic                    clearIn,
  input  logic [NUM_CH-1:0]       overHit,
  input  logic [NUM_CH-1:0]       openHit,
  input  logic [NUM_CH-1:0]       shortHit,
  input  logic [NUM_CH-1:0]       shortDone,
  output logic [NUM_CH-1:0]       gateEn,
  output logic [NUM_CH-1:0]       onQual,
  output logic [NUM_CH-1:0]       offQual,
  output chStrobe_t [NUM_CH-1:0]  strobe,
  output logic                    wipe
);

  logic              active;
  logic [NUM_CH-1:0] offLatch;

  assign active = rstN & ~uvFlag;
  assign wipe   = clearIn | uvFlag;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    // overload latch: set by a completed overload dwell, released by a high command
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            offLatch[ch] <= 1'b0;
      else if (uvFlag)      offLatch[ch] <= 1'b0;
      else if (cmdN[ch])    offLatch[ch] <= 1'b0;
      else if (overHit[ch]) offLatch[ch] <= 1'b1;
    end

    assign gateEn[ch]  = active & ~cmdN[ch] & ~offLatch[ch];
    assign onQual[ch]  = gateEn[ch];
    assign offQual[ch] = active & cmdN[ch];

    always_comb begin
      strobe[ch].recOver  = overHit[ch];
      strobe[ch].recShort = shortHit[ch];
      strobe[ch].recOpen  = openHit[ch] & ~shortHit[ch] & ~shortDone[ch];
    end
  end

endmodule

// File: rtl/load_fault_supervisor.sv
module load_fault_supervisor
  import lfs_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int OVER_CYCLES  = 8,
  parameter int OPEN_CYCLES  = 50,
  parameter int SHORT_CYCLES = 30
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                uvFlag,
  input  logic [NUM_CH-1:0]   cmdN,
  input  logic [NUM_CH-1:0]   overFlag,
  input  logic [NUM_CH-1:0]   openFlag,
  input  logic [NUM_CH-1:0]   shortFlag,
  input  logic                clearCodes,
  output logic [NUM_CH-1:0]   gateEn,
  output logic [2*NUM_CH-1:0] errCode,
  output logic [NUM_CH-1:0]   errPulse
);

  logic [NUM_CH-1:0]      onQual, offQual;
  logic [NUM_CH-1:0]      overHit, openHit, shortHit, shortDone;
  chStrobe_t [NUM_CH-1:0] strobe;
  logic                   wipe;

  lfs_control #(.NUM_CH(NUM_CH)) u_control (
    .clk(clk), .rstN(rstN), .uvFlag(uvFlag), .cmdN(cmdN), .clearIn(clearCodes),
    .overHit(overHit), .openHit(openHit), .shortHit(shortHit), .shortDone(shortDone),
    .gateEn(gateEn), .onQual(onQual), .offQual(offQual), .strobe(strobe), .wipe(wipe));

  lfs_datapath #(
    .NUM_CH(NUM_CH), .OVER_CYCLES(OVER_CYCLES),
    .OPEN_CYCLES(OPEN_CYCLES), .SHORT_CYCLES(SHORT_CYCLES)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .overFlag(overFlag), .openFlag(openFlag),
    .shortFlag(shortFlag), .onQual(onQual), .offQual(offQual), .strobe(strobe),
    .wipe(wipe), .overHit(overHit), .openHit(openHit), .shortHit(shortHit),
    .shortDone(shortDone), .errCode(errCode), .errPulse(errPulse));

endmodule

// File: rtl/lfs_checker.sv
module lfs_checker #(
  parameter int NUM_CH = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                uvFlag,
  input logic [NUM_CH-1:0]   cmdN,
  input logic                clearCodes,
  input logic [NUM_CH-1:0]   gateEn,
  input logic [2*NUM_CH-1:0] errCode,
  input logic [NUM_CH-1:0]   errPulse
);

  AST_UV_GATES_OFF: assert property (@(posedge clk) disable iff (!rstN)
    uvFlag |-> (gateEn == '0)); // R8

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    AST_GATE_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rstN)
      gateEn[i] |-> !cmdN[i]); // R1

    AST_OVER_SHUTDOWN_CODE: assert property (@(posedge clk) disable iff (!rstN)
      ($past(gateEn[i]) && !gateEn[i] && !cmdN[i] && $past(!cmdN[i])
        && !uvFlag && !$past(uvFlag)) |-> (errCode[2*i +: 2] == 2'b10)); // R2

    AST_LATCH_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(!gateEn[i] && !cmdN[i] && !uvFlag) && !cmdN[i] && !uvFlag)
        |-> !gateEn[i]); // R3

    AST_PULSE_WITH_CODE: assert property (@(posedge clk) disable iff (!rstN)
      errPulse[i] |-> (errCode[2*i +: 2] != 2'b11)); // R10

    AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (!rstN)
      clearCodes |=> (errPulse[i] || errCode[2*i +: 2] == 2'b11)); // R9
  end

endmodule

bind load_fault_supervisor lfs_checker #(.NUM_CH(NUM_CH)) u_lfsChecker (
  .clk(clk), .rstN(rstN), .uvFlag(uvFlag), .cmdN(cmdN), .clearCodes(clearCodes),
  .gateEn(gateEn), .errCode(errCode), .errPulse(errPulse));

// File: tb/test_load_fault_supervisor.sv
module test_load_fault_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int OV  = 8;
  localparam int OL  = 50;
  localparam int SG  = 30;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           uvFlag = 1'b0;
  logic [NCH-1:0] cmdN = '1;
  logic [NCH-1:0] overFlag = '0, openFlag = '0, shortFlag = '0;
  logic           clearCodes = 1'b0;
  logic [NCH-1:0] gateEn;
  logic [2*NCH-1:0] errCode;
  logic [NCH-1:0] errPulse;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_fault_supervisor #(
    .NUM_CH(NCH), .OVER_CYCLES(OV), .OPEN_CYCLES(OL), .SHORT_CYCLES(SG)
  ) i_load_fault_supervisor (
    .clk(clk), .rstN(rstN), .uvFlag(uvFlag), .cmdN(cmdN), .overFlag(overFlag),
    .openFlag(openFlag), .shortFlag(shortFlag), .clearCodes(clearCodes),
    .gateEn(gateEn), .errCode(errCode), .errPulse(errPulse));

  // ---------------- reference model from the requirements ----------------
  int unsigned    cOv[NCH], cOl[NCH], cSg[NCH];
  logic [NCH-1:0] mLat = '0, mPulse = '0;
  logic [1:0]     mCode[NCH];

  function automatic logic [NCH-1:0] expGate();
    logic [NCH-1:0] g;
    for (int ch = 0; ch < NCH; ch++)
      g[ch] = rstN && !uvFlag && !cmdN[ch] && !mLat[ch];
    return g;
  endfunction

  function automatic logic [2*NCH-1:0] expCodes();
    logic [2*NCH-1:0] v;
    for (int ch = 0; ch < NCH; ch++) v[2*ch +: 2] = mCode[ch];
    return v;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN || uvFlag) begin
      for (int ch = 0; ch < NCH; ch++) begin
        cOv[ch] = 0; cOl[ch] = 0; cSg[ch] = 0; mCode[ch] = 2'b11;
      end
      mLat = '0; mPulse = '0;
    end else begin
      logic [NCH-1:0] g;
      g = expGate();
      for (int ch = 0; ch < NCH; ch++) begin
        logic ovRun, olRun, sgRun, ovHit, olHit, sgHit, sgExp;
        ovRun = overFlag[ch] && g[ch];
        olRun = openFlag[ch] && cmdN[ch];
        sgRun = shortFlag[ch] && cmdN[ch];
        ovHit = ovRun && (cOv[ch] == OV-1);
        olHit = olRun && (cOl[ch] == OL-1);
        sgHit = sgRun && (cSg[ch] == SG-1);
        sgExp = (cSg[ch] == SG);
        cOv[ch] = !ovRun ? 0 : (cOv[ch] < OV ? cOv[ch] + 1 : cOv[ch]);
        cOl[ch] = !olRun ? 0 : (cOl[ch] < OL ? cOl[ch] + 1 : cOl[ch]);
        cSg[ch] = !sgRun ? 0 : (cSg[ch] < SG ? cSg[ch] + 1 : cSg[ch]);
        mPulse[ch] = 1'b1;
        if (ovHit)                 begin mCode[ch] = 2'b10; mLat[ch] = 1'b1; end
        else if (sgHit)            mCode[ch] = 2'b00;
        else if (olHit && !sgExp)  mCode[ch] = 2'b01;
        else begin
          mPulse[ch] = 1'b0;
          if (clearCodes) mCode[ch] = 2'b11;
        end
        if (cmdN[ch]) mLat[ch] = 1'b0;
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic expectVal(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareModel(string tag);
    expectVal({tag, " R1 gate vs model"}, 32'(gateEn), 32'(expGate()));
    expectVal({tag, " R10 codes vs model"}, 32'(errCode), 32'(expCodes()));
    expectVal({tag, " R10 pulses vs model"}, 32'(errPulse), 32'(mPulse));
  endtask

  // advance n edges, sampling 1 time unit after each edge
  task automatic cyc(int n, string tag);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      compareModel(tag);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd20240611);

    cyc(3, "reset");
    expectVal("R8 reset codes", 32'(errCode), 32'hFF);
    expectVal("R8 reset gates", 32'(gateEn), 32'h0);
    expectVal("R8 reset pulses", 32'(errPulse), 32'h0);
    rstN = 1'b1;
    cyc(2, "idle");

    // R1: gate follows active-low command
    cmdN = 4'b1010; cyc(1, "R1");
    expectVal("R1 gate pattern a", 32'(gateEn), 32'h5);
    cmdN = 4'b0110; cyc(1, "R1");
    expectVal("R1 gate pattern b", 32'(gateEn), 32'h9);

    // R2: overload on channel 0
    cmdN = 4'b1110; overFlag[0] = 1'b1;
    cyc(OV-1, "R2");
    expectVal("R2 code before dwell", 32'(errCode[1:0]), 32'h3);
    expectVal("R2 gate before dwell", 32'(gateEn[0]), 32'h1);
    cyc(1, "R2");
    expectVal("R2 overload code", 32'(errCode[1:0]), 32'h2);
    expectVal("R2 gate shut off", 32'(gateEn[0]), 32'h0);
    expectVal("R10 pulse after overload", 32'(errPulse[0]), 32'h1);
    overFlag[0] = 1'b0;

    // R3: stays off while held low, re-enables after a toggle
    cyc(5, "R3");
    expectVal("R3 held low stays off", 32'(gateEn[0]), 32'h0);
    expectVal("R10 pulse lasts one cycle", 32'(errPulse[0]), 32'h0);
    cmdN[0] = 1'b1; cyc(1, "R3");
    cmdN[0] = 1'b0; cyc(1, "R3");
    expectVal("R3 re-enabled after toggle", 32'(gateEn[0]), 32'h1);

    // R4: open load on channel 1 (commanded off)
    openFlag[1] = 1'b1;
    cyc(OL-1, "R4");
    expectVal("R4 code before dwell", 32'(errCode[3:2]), 32'h3);
    cyc(1, "R4");
    expectVal("R4 open-load code", 32'(errCode[3:2]), 32'h1);

    // R11: holding the flag gives no further pulse
    cyc(20, "R11");
    expectVal("R11 no repeat pulse", 32'(errPulse[1]), 32'h0);
    openFlag[1] = 1'b0;

    // R5: short wins over open load on channel 2
    openFlag[2] = 1'b1; shortFlag[2] = 1'b1;
    cyc(SG, "R5");
    expectVal("R5 short code", 32'(errCode[5:4]), 32'h0);
    cyc(OL, "R5");
    expectVal("R5 short keeps priority", 32'(errCode[5:4]), 32'h0);
    openFlag[2] = 1'b0; shortFlag[2] = 1'b0;

    // R6: restart by a one-edge gap and by an on/off flip on channel 3
    shortFlag[3] = 1'b1; cyc(SG-1, "R6");
    shortFlag[3] = 1'b0; cyc(1, "R6");
    shortFlag[3] = 1'b1; cyc(SG-1, "R6");
    expectVal("R6 flag gap restarts", 32'(errCode[7:6]), 32'h3);
    cmdN[3] = 1'b0; cyc(1, "R6");
    cmdN[3] = 1'b1; cyc(SG-1, "R6");
    expectVal("R6 state flip restarts", 32'(errCode[7:6]), 32'h3);
    cyc(1, "R6");
    expectVal("R6 completes after restart", 32'(errCode[7:6]), 32'h0);
    shortFlag[3] = 1'b0;

    // R7: overwrite existing codes
    shortFlag[1] = 1'b1; cyc(SG, "R7");
    expectVal("R7 open replaced by short", 32'(errCode[3:2]), 32'h0);
    shortFlag[1] = 1'b0;
    cmdN[0] = 1'b1; cyc(1, "R7");
    cmdN[0] = 1'b0; overFlag[0] = 1'b1; cyc(OV, "R7");
    cmdN[0] = 1'b1; overFlag[0] = 1'b0; openFlag[0] = 1'b1; cyc(OL, "R7");
    expectVal("R7 overload replaced by open", 32'(errCode[1:0]), 32'h1);
    openFlag[0] = 1'b0;

    // R9: clear, then clear colliding with a record
    clearCodes = 1'b1; cyc(1, "R9"); clearCodes = 1'b0;
    expectVal("R9 clear wipes all", 32'(errCode), 32'hFF);
    openFlag[1] = 1'b1; cyc(OL-1, "R9");
    clearCodes = 1'b1; cyc(1, "R9"); clearCodes = 1'b0;
    expectVal("R9 record wins over clear", 32'(errCode), 32'hF7);
    openFlag[1] = 1'b0;

    // R8: undervoltage wipes codes and latches
    cmdN[0] = 1'b0; overFlag[0] = 1'b1; cyc(OV, "R8");
    expectVal("R8 latch set before uv", 32'(gateEn[0]), 32'h0);
    uvFlag = 1'b1; overFlag[0] = 1'b0; cyc(1, "R8");
    expectVal("R8 uv codes", 32'(errCode), 32'hFF);
    expectVal("R8 uv gates", 32'(gateEn), 32'h0);
    uvFlag = 1'b0; cyc(1, "R8");
    expectVal("R8 latch released by uv", 32'(gateEn[0]), 32'h1);

    // random phase with slowly changing inputs
    for (int n = 0; n < 6000; n++) begin
      for (int ch = 0; ch < NCH; ch++) begin
        if ($urandom % 16 == 0) cmdN[ch]      = ~cmdN[ch];
        if ($urandom % 12 == 0) overFlag[ch]  = ~overFlag[ch];
        if ($urandom % 12 == 0) openFlag[ch]  = ~openFlag[ch];
        if ($urandom % 12 == 0) shortFlag[ch] = ~shortFlag[ch];
      end
      clearCodes = ($urandom % 64 == 0);
      uvFlag     = ($urandom % 300 == 0);
      rstN       = ($urandom % 700 != 0);
      cyc(1, "random");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule